// File: doc/BRIEF.md
# Memory Access Coalescing Unit

This block takes one group of per-lane memory requests at a time and turns it into the smallest set of aligned segment transactions that covers every active lane. All lanes in a group share one access width. Each lane supplies an address and an active bit. The unit sends the transactions one by one to a downstream memory port over a valid/ready handshake. With each transaction it sends the aligned segment base and a lane mask, which tells the return path which lanes the fetched segment serves.

There are two modes. In the base mode only the lower sixteen lanes take part, and the segment size follows the access width. In the cached mode all thirty-two lanes take part and the segment is always a 128-byte line. When the addresses in a group cross a segment boundary, the group is split into one transaction per segment touched. The transactions go out from the lowest address to the highest. The input stays stalled until the last transaction of the group has been taken downstream.

Top module: `coalesce_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In base mode, the segment size is set by `in_size`: 0 (8-bit) gives 32 bytes, 1 (16-bit) gives 64 bytes, and 2 (32-bit) or 3 (64-bit) give 128 bytes. `out_addr` is the lane address with its low bits cleared down to that segment size.
- R3: When all active lanes fall in one aligned segment, exactly one transaction is issued, and its mask holds every active lane.
- R4: When the active lanes touch several segments, exactly one transaction is issued per distinct segment, in strictly ascending `out_addr` order.
- R5: In cached mode (`in_cached`=1), all 32 lanes take part and every segment is a 128-byte line, whatever `in_size` is.
- R6: In base mode, lanes 16 to 31 are ignored, and bits 31:16 of `out_mask` stay 0.
- R7: Lanes with `in_active` bit 0 are ignored, whatever their address.
- R8: A group with no participating active lane is accepted in one cycle. It issues no transaction, and `in_ready` is 1 again on the next cycle.
- R9: `in_ready` is 0 from the cycle after a group is accepted until the cycle after its last transaction handshake.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_mask` hold their values.
- R11: Every participating active lane appears in exactly one transaction mask of its group, and no other lane appears in any of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request group is presented |
| in_ready | output | 1 | The unit can accept a group |
| in_cached | input | 1 | 1: 32-lane, 128-byte line mode; 0: 16-lane base mode |
| in_size | input | 2 | Access width: 0=8, 1=16, 2=32, 3=64 bits |
| in_active | input | LANES | Per-lane active bits |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | Downstream takes the transaction |
| out_addr | output | ADDR_W | Aligned segment base address |
| out_mask | output | LANES | Lanes served by this transaction |

## Verification
The hardest case to reach from the ports is a split group whose lane order does not match its address order, with the downstream port stalling in the middle of the group. In that case the ascending issue order, the hold of the offered transaction, and the removal of served lanes all have to hold at once. The stimulus builds such a group from descending and scattered lane addresses. It toggles `out_ready` every other cycle, so each transaction sits stalled for a cycle before it is taken. A behavioural model collects the distinct segments and sorts them, and each handshake is compared against that sorted list.

// File: rtl/coalesce_unit.sv
module coalesce_unit #(
  parameter int ADDR_W        = 32,
  parameter int LANES         = 32,
  parameter int BASE_LANES    = 16,
  parameter int SEG_MIN_BYTES = 32,
  parameter int LINE_BYTES    = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_cached,
  input  logic [1:0]              in_size,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [LANES-1:0]        out_mask
);
  localparam int SEG_LOG  = $clog2(SEG_MIN_BYTES);
  localparam int LINE_LOG = $clog2(LINE_BYTES);
  localparam int SH_W     = $clog2(ADDR_W);
  localparam logic [LANES-1:0] BASE_MASK = {{(LANES-BASE_LANES){1'b0}}, {BASE_LANES{1'b1}}};

  logic              busy;
  logic [LANES-1:0]  pend;
  logic [SH_W-1:0]   shamt_q;
  logic [ADDR_W-1:0] idx_q [LANES];

  logic [SH_W-1:0]   shamt_d;
  logic [LANES-1:0]  take;
  logic [ADDR_W-1:0] min_idx;
  logic              found;
  logic [LANES-1:0]  hit;
  logic [LANES-1:0]  left;

  assign take = in_active & (in_cached ? {LANES{1'b1}} : BASE_MASK);

  always_comb begin
    if (in_cached)          shamt_d = SH_W'(LINE_LOG);
    else if (in_size == 2'd0) shamt_d = SH_W'(SEG_LOG);
    else if (in_size == 2'd1) shamt_d = SH_W'(SEG_LOG + 1);
    else                      shamt_d = SH_W'(SEG_LOG + 2);
  end

  always_comb begin
    min_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || idx_q[i] < min_idx)) begin
        min_idx = idx_q[i];
        found   = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++)
      hit[i] = pend[i] && (idx_q[i] == min_idx);
  end

  assign left      = pend & ~hit;
  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_addr  = min_idx << shamt_q;
  assign out_mask  = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pend    <= '0;
      shamt_q <= '0;
    end else if (in_valid && !busy) begin
      busy    <= |take;
      pend    <= take;
      shamt_q <= shamt_d;
    end else if (busy && out_ready) begin
      busy <= |left;
      pend <= left;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !busy)
      for (int i = 0; i < LANES; i++)
        idx_q[i] <= in_addr[i*ADDR_W +: ADDR_W] >> shamt_d;
  end
endmodule

// File: rtl/coalesce_unit_chk.sv
module coalesce_unit_chk #(
  parameter int ADDR_W        = 32,
  parameter int LANES         = 32,
  parameter int BASE_LANES    = 16,
  parameter int SEG_MIN_BYTES = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_cached,
  input logic [1:0]              in_size,
  input logic [LANES-1:0]        in_active,
  input logic [LANES*ADDR_W-1:0] in_addr,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [ADDR_W-1:0]       out_addr,
  input logic [LANES-1:0]        out_mask
);
  localparam logic [LANES-1:0] BASE_MASK = {{(LANES-BASE_LANES){1'b0}}, {BASE_LANES{1'b1}}};

  logic [LANES-1:0]  act_q, served_q, take;
  logic              mode_q, seen_q;
  logic [ADDR_W-1:0] last_q;

  assign take = in_active & (in_cached ? {LANES{1'b1}} : BASE_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0; served_q <= '0; mode_q <= 1'b0; seen_q <= 1'b0; last_q <= '0;
    end else if (in_valid && in_ready) begin
      act_q <= take; served_q <= '0; mode_q <= in_cached; seen_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      served_q <= served_q | out_mask; seen_q <= 1'b1; last_q <= out_addr;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask));
  assert_input_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr % SEG_MIN_BYTES) == 0);
  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_q |-> out_addr > last_q);
  assert_upper_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mode_q |-> (out_mask & ~BASE_MASK) == '0);
  assert_once_each_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0 && (out_mask & served_q) == '0 && (out_mask & ~act_q) == '0);
  assert_empty_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && take == '0 |=> in_ready);
endmodule

bind coalesce_unit coalesce_unit_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BASE_LANES(BASE_LANES), .SEG_MIN_BYTES(SEG_MIN_BYTES)
) u_chk (.*);

// File: tb/coalesce_unit_tb.sv
module coalesce_unit_tb;
  localparam int AW = 32;
  localparam int NL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_cached = 1'b0;
  logic [1:0] in_size = 2'd0;
  logic [NL-1:0] in_active = '0;
  logic [NL*AW-1:0] in_addr;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [AW-1:0] out_addr;
  logic [NL-1:0] out_mask;

  logic [AW-1:0] lane_addr [NL];
  logic [AW-1:0] exp_addr [NL];
  logic [NL-1:0] exp_mask [NL];
  int exp_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NL; i++) in_addr[i*AW +: AW] = lane_addr[i];

  coalesce_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cached(in_cached), .in_size(in_size), .in_active(in_active), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_mask(out_mask));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [AW-1:0] base, input int stride);
    for (int i = 0; i < NL; i++) lane_addr[i] = base + AW'(i * stride);
  endtask

  task automatic model(input bit cached, input logic [1:0] size, input logic [NL-1:0] act);
    logic [AW-1:0] seg, b, ta;
    logic [NL-1:0] tm;
    bit hitf;
    int lanes;
    seg = cached ? 128 : (size == 0 ? 32 : (size == 1 ? 64 : 128));
    lanes = cached ? 32 : 16;
    exp_n = 0;
    for (int l = 0; l < lanes; l++) begin
      if (act[l]) begin
        b = lane_addr[l] & ~(seg - 1);
        hitf = 1'b0;
        for (int j = 0; j < exp_n; j++)
          if (exp_addr[j] == b) begin exp_mask[j][l] = 1'b1; hitf = 1'b1; end
        if (!hitf) begin
          exp_addr[exp_n] = b; exp_mask[exp_n] = '0; exp_mask[exp_n][l] = 1'b1; exp_n++;
        end
      end
    end
    for (int p = 0; p < exp_n; p++)
      for (int q = 0; q + 1 < exp_n - p; q++)
        if (exp_addr[q] > exp_addr[q+1]) begin
          ta = exp_addr[q]; exp_addr[q] = exp_addr[q+1]; exp_addr[q+1] = ta;
          tm = exp_mask[q]; exp_mask[q] = exp_mask[q+1]; exp_mask[q+1] = tm;
        end
  endtask

  task automatic run_group(input string req, input bit cached, input logic [1:0] size,
                           input logic [NL-1:0] act, input bit stall);
    int got, cyc;
    bit held;
    logic [AW-1:0] h_addr;
    logic [NL-1:0] h_mask;
    model(cached, size, act);
    @(negedge clk);
    in_valid = 1'b1; in_cached = cached; in_size = size; in_active = act;
    chk(in_ready === 1'b1, "R9", "ready before group", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    got = 0; cyc = 0; held = 1'b0;
    while (got < exp_n && cyc < 200) begin
      out_ready = stall ? cyc[0] : 1'b1;
      if (held) begin
        chk(out_valid && out_addr == h_addr && out_mask == h_mask, "R10", "stalled hold",
            64'(out_addr), 64'(h_addr));
        held = 1'b0;
      end
      chk(in_ready === 1'b0, "R9", "ready while group pending", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        chk(out_addr == exp_addr[got], req, "transaction address", 64'(out_addr), 64'(exp_addr[got]));
        chk(out_mask == exp_mask[got], req, "transaction mask", 64'(out_mask), 64'(exp_mask[got]));
        got++;
      end else if (out_valid) begin
        held = 1'b1; h_addr = out_addr; h_mask = out_mask;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(got == exp_n, req, "transaction count", 64'(got), 64'(exp_n));
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R9", "idle after last handshake",
        64'({in_ready, out_valid}), 64'b10);
  endtask

  task automatic t_reset;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "reset state", 64'({in_ready, out_valid}), 64'b10);
  endtask

  task automatic t_byte_single;   fill(32'h1000, 1); run_group("R2", 0, 2'd0, 32'hFFFF, 0); endtask
  task automatic t_half_single;   fill(32'h2010, 2); run_group("R3", 0, 2'd1, 32'hFFFF, 0); endtask
  task automatic t_dword_split;   fill(32'h3040, 8); run_group("R4", 0, 2'd3, 32'hFFFF, 1); endtask
  task automatic t_word_descend;
    for (int i = 0; i < NL; i++) lane_addr[i] = 32'h5000 + AW'((15 - i) * 16);
    run_group("R4", 0, 2'd2, 32'hFFFF, 1);
  endtask
  task automatic t_byte_scatter;
    for (int i = 0; i < NL; i++) lane_addr[i] = 32'h8000 + AW'(((i * 7) % 16) * 40 + i);
    run_group("R4", 0, 2'd0, 32'hFFFF, 1);
  endtask
  task automatic t_inactive;
    fill(32'h6000, 4);
    for (int i = 0; i < NL; i++) if (((i / 4) % 2) == 1) lane_addr[i] = 32'hF000_0000 + AW'(i * 4096);
    run_group("R7", 0, 2'd2, 32'h0F0F, 0);
  endtask
  task automatic t_upper_ignored;
    fill(32'h7000, 4);
    for (int i = 16; i < NL; i++) lane_addr[i] = 32'h9000_0000 + AW'(i * 512);
    run_group("R6", 0, 2'd2, 32'hFFFF_FFFF, 0);
  endtask
  task automatic t_cached_line;   fill(32'h4000, 4); run_group("R5", 1, 2'd0, 32'hFFFF_FFFF, 0); endtask
  task automatic t_cached_split;  fill(32'h4040, 4); run_group("R5", 1, 2'd2, 32'hFFFF_FFFF, 1); endtask
  task automatic t_broadcast;     fill(32'hA0C4, 0); run_group("R11", 1, 2'd1, 32'h8421_F00F, 0); endtask
  task automatic t_empty;
    fill(32'hB000, 4);
    run_group("R8", 0, 2'd2, 32'h0000_0000, 0);
    run_group("R8", 0, 2'd0, 32'hFFFF_0000, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill(32'h0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_byte_single();
    t_half_single();
    t_dword_split();
    t_word_descend();
    t_byte_scatter();
    t_inactive();
    t_upper_ignored();
    t_cached_line();
    t_cached_split();
    t_broadcast();
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule